// File: doc/BRIEF.md
# Serial Command Decoder for a Character Overlay

This block takes 8-bit words from a three-wire synchronous serial link: a serial clock, a data line and an active-low chip select. It turns them into control-register updates and display-memory writes for a text overlay engine. A word with its top bit set names a command. Words with the top bit clear carry data for the command that was named most recently. That command stays in force until another command word arrives, so one command can take any number of data words.

The memory it feeds holds a grid of character cells, 10 rows of 24 columns by default. One command selects the cell. Another command switches the decoder into a streaming mode, where every word is a character and the cell position steps forward after each write. Raising chip select ends that mode. Other commands set the vertical and horizontal start position and the character size, the display-control flags and the sync-control flags. The display-control command can also start a memory erase or a register reset. The erase writes the blank code into every cell, but only while the display is switched off.

The serial lines are brought into the system clock domain through synchronizers. All decoding runs on the system clock.

Top module: `osd_cmd_decoder`

## Requirements
- R1: A word is 8 bits, shifted in MSB first on rising serial-clock edges while chip select is low. Serial-clock edges while chip select is high are ignored. A word left incomplete when chip select rises is thrown away.
- R2: A word with bit 7 = 1 is a command word, and its bits 6:4 hold the command code. Codes 6 and 7 are not defined. While one of them is current, data words change no register and write no memory.
- R3: The current command code stays in force for every data word (bit 7 = 0) that follows, until the next command word.
- R4: Code 0 sets the write cell. The command word's bits 3:0 give the row. A data word's bits 4:0 give the column.
- R5: Code 1 (for example 0x90) locks the decoder. Every later word, including one with bit 7 = 1, is character data until chip select rises.
- R6: A character word writes to the current cell with ram_wdata = {word[7], word[5:0]}: bit 6 is the attribute and bits 5:0 are the character code. Word bit 6 is ignored.
- R7: Each accepted character write moves to the next column. After column 23 it goes to column 0 of the next row. After row 9 it goes back to row 0.
- R8: A character write to a row of 10 or more, or to a column of 24 or more, produces no write strobe and leaves the cell position unchanged.
- R9: A rising edge on chip select makes code 0 the current command again and ends the lock. The row already set is kept.
- R10: Code 2 sets the vertical fields and code 3 the horizontal ones. In the command word, bit 2 is the second-line size and bit 0 the first-line size. In a data word, bits 5:0 are the start position.
- R11: Under code 4, a data word's bits 6:0 go to disp_ctrl, and bit 0 is display-on. A code 5 command word copies its bits 2:0 to sync_ctrl.
- R12: A code 4 command word with bit 2 = 1 and bit 0 = 0 requests an erase. The erase writes 0x3F into all 240 cells, one cell per clock, and only while disp_ctrl[0] = 0. While the display is on, the request waits.
- R13: A code 4 command word with bit 0 = 1 clears all register outputs and the cell position. It then holds them cleared, ignoring every word, until chip select rises.
- R14: After rst_n, every register output is zero and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_csn | input | 1 | Active-low chip select |
| vpos | output | 6 | Vertical start position |
| vsize | output | 2 | Vertical size, {second line, first line} |
| hpos | output | 6 | Horizontal start position |
| hsize | output | 2 | Horizontal size, {second line, first line} |
| disp_ctrl | output | 7 | Display-control flags; bit 0 is display-on |
| sync_ctrl | output | 3 | Sync-control flags |
| ram_we | output | 1 | Display-memory write strobe |
| ram_row | output | 4 | Write row |
| ram_col | output | 5 | Write column |
| ram_wdata | output | 7 | Write data {attribute, code} |

## Verification
The hardest state to reach is an erase that has been requested while the display is on. The bench first turns the display on. It then sends the erase command and watches for a long stretch to confirm that no write strobe appears. Only then does it send the data word that turns the display off. At that point it expects exactly 240 blank writes, covering every cell once. The lock is probed with a character word that has bit 7 set and would otherwise be taken as a size command. The wraps are reached by placing the cell at the last column of a row.

// File: rtl/osd_pkg.sv
// Package: shared constants and types for the serial command decoder.
// Assumes the fixed 8-bit word format; grid size defaults live here.
package osd_pkg;
    localparam int WORD_W   = 8;
    localparam int ROW_W    = 4;
    localparam int COL_W    = 5;
    localparam int CHAR_W   = 7;
    localparam int POS_W    = 6;
    localparam int CODE_W   = 3;
    localparam int DEF_ROWS = 10;
    localparam int DEF_COLS = 24;

    localparam logic [CODE_W-1:0] CMD_ADDR = 3'd0;
    localparam logic [CODE_W-1:0] CMD_CHAR = 3'd1;
    localparam logic [CODE_W-1:0] CMD_VERT = 3'd2;
    localparam logic [CODE_W-1:0] CMD_HORZ = 3'd3;
    localparam logic [CODE_W-1:0] CMD_DISP = 3'd4;
    localparam logic [CODE_W-1:0] CMD_SYNC = 3'd5;

    localparam logic [CHAR_W-1:0] BLANK_CHAR = 7'h3F;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [1:0]       size;
    } axis_cfg_t;
endpackage

// File: rtl/osd_ser_rx.sv
// Serial receiver: synchronizes the three serial lines to clk, detects
// rising serial-clock edges while chip select is low and frames 8-bit words.
// Assumes the serial clock is much slower than clk (several clk per half period).
module osd_ser_rx
    import osd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_csn,
    output logic              word_vld,
    output logic [WORD_W-1:0] word,
    output logic              cs_rise
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic [SYNC_STAGES-1:0] sclk_p, dat_p, csn_p;
    logic sclk_s, dat_s, csn_s, sclk_q, csn_q, sclk_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;

    // Synchronizer chains; chip select resets to inactive
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_p <= '0; dat_p <= '0; csn_p <= '1;
                end else begin
                    sclk_p <= ser_clk; dat_p <= ser_dat; csn_p <= ser_csn;
                end
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_p <= '0; dat_p <= '0; csn_p <= '1;
                end else begin
                    sclk_p <= {sclk_p[SYNC_STAGES-2:0], ser_clk};
                    dat_p  <= {dat_p[SYNC_STAGES-2:0], ser_dat};
                    csn_p  <= {csn_p[SYNC_STAGES-2:0], ser_csn};
                end
            end
        end
    endgenerate

    assign sclk_s = sclk_p[SYNC_STAGES-1];
    assign dat_s  = dat_p[SYNC_STAGES-1];
    assign csn_s  = csn_p[SYNC_STAGES-1];

    // Previous-value flops for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_rise   = csn_s & ~csn_q;

    // Shift and frame: counter restarts whenever chip select is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                shreg   <= {shreg[WORD_W-2:0], dat_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    word     <= {shreg[WORD_W-2:0], dat_s};
                    word_vld <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_cmd_fsm.sv
// Command interpreter: holds the sticky command code and the character-write
// lock, updates the configuration registers, tracks the write cell and issues
// registered character writes. Assumes at most one word per clock.
module osd_cmd_fsm
    import osd_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              cs_rise,
    output logic [CODE_W-1:0] cur_cmd,
    output logic              locked,
    output logic              sys_hold,
    output axis_cfg_t         vcfg,
    output axis_cfg_t         hcfg,
    output logic [6:0]        disp_ctrl,
    output logic [2:0]        sync_ctrl,
    output logic              erase_req,
    output logic              ser_we,
    output logic [ROW_W-1:0]  ser_row,
    output logic [COL_W-1:0]  ser_col,
    output logic [CHAR_W-1:0] ser_wdata
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [CODE_W-1:0] code;
    logic live, is_first, is_data, rst_hit, char_ok, clear_cfg;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;

    // Classify the incoming word
    always_comb begin
        code      = word[6:4];
        live      = word_vld && !sys_hold;
        is_first  = live && !locked && word[WORD_W-1];
        is_data   = live && (locked || !word[WORD_W-1]);
        rst_hit   = is_first && (code == CMD_DISP) && word[0];
        erase_req = is_first && (code == CMD_DISP) && word[2] && !word[0];
        char_ok   = is_data && (cur_cmd == CMD_CHAR) && (row <= LAST_ROW) && (col <= LAST_COL);
        clear_cfg = rst_hit || sys_hold;
    end

    // Sticky command code and lock; chip-select rise returns to address mode
    always_ff @(posedge clk) begin
        if (!rst_n || cs_rise) begin
            cur_cmd <= CMD_ADDR;
            locked  <= 1'b0;
        end else if (is_first) begin
            cur_cmd <= code;
            locked  <= (code == CMD_CHAR);
        end
    end

    // Register-reset hold, released by chip-select rise
    always_ff @(posedge clk) begin
        if (!rst_n || cs_rise) sys_hold <= 1'b0;
        else if (rst_hit)      sys_hold <= 1'b1;
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear_cfg) begin
            vcfg      <= '0;
            hcfg      <= '0;
            disp_ctrl <= '0;
            sync_ctrl <= '0;
        end else if (is_first) begin
            case (code)
                CMD_VERT: vcfg.size <= {word[2], word[0]};
                CMD_HORZ: hcfg.size <= {word[2], word[0]};
                CMD_SYNC: sync_ctrl <= word[2:0];
                default: ;
            endcase
        end else if (is_data) begin
            case (cur_cmd)
                CMD_VERT: vcfg.pos  <= word[POS_W-1:0];
                CMD_HORZ: hcfg.pos  <= word[POS_W-1:0];
                CMD_DISP: disp_ctrl <= word[6:0];
                default: ;
            endcase
        end
    end

    // Write cell tracking with auto-advance and wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clear_cfg) begin
            row <= '0;
            col <= '0;
        end else if (is_first && code == CMD_ADDR) begin
            row <= word[ROW_W-1:0];
        end else if (is_data && cur_cmd == CMD_ADDR) begin
            col <= word[COL_W-1:0];
        end else if (char_ok) begin
            if (col == LAST_COL) begin
                col <= '0;
                row <= (row == LAST_ROW) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    // Registered character write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_we    <= 1'b0;
            ser_row   <= '0;
            ser_col   <= '0;
            ser_wdata <= '0;
        end else begin
            ser_we    <= char_ok;
            ser_row   <= row;
            ser_col   <= col;
            ser_wdata <= {word[WORD_W-1], word[5:0]};
        end
    end
endmodule

// File: rtl/osd_erase_seq.sv
// Erase sequencer: after a request, walks every cell and writes the blank
// code, one cell per clock, only while the display is off and the serial
// path is not writing. Assumes clr aborts a pending erase.
module osd_erase_seq
    import osd_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              erase_req,
    input  logic              disp_on,
    input  logic              stall,
    output logic              er_we,
    output logic [ROW_W-1:0]  er_row,
    output logic [COL_W-1:0]  er_col,
    output logic [CHAR_W-1:0] er_data
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic pend;

    // Write enable when pending and allowed
    assign er_we   = pend && !disp_on && !stall;
    assign er_data = BLANK_CHAR;

    // Pending flag and cell walk
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend   <= 1'b0;
            er_row <= '0;
            er_col <= '0;
        end else if (erase_req && !pend) begin
            pend   <= 1'b1;
            er_row <= '0;
            er_col <= '0;
        end else if (er_we) begin
            if (er_col == LAST_COL) begin
                er_col <= '0;
                if (er_row == LAST_ROW) begin
                    er_row <= '0;
                    pend   <= 1'b0;
                end else begin
                    er_row <= er_row + 1'b1;
                end
            end else begin
                er_col <= er_col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osd_cmd_decoder.sv
// Top: serial receiver, command interpreter and erase sequencer, with the
// memory write port shared (serial writes win, erase stalls for that clock).
module osd_cmd_decoder
    import osd_pkg::*;
#(
    parameter int ROWS        = DEF_ROWS,
    parameter int COLS        = DEF_COLS,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        ser_csn,
    output logic [5:0]  vpos,
    output logic [1:0]  vsize,
    output logic [5:0]  hpos,
    output logic [1:0]  hsize,
    output logic [6:0]  disp_ctrl,
    output logic [2:0]  sync_ctrl,
    output logic        ram_we,
    output logic [3:0]  ram_row,
    output logic [4:0]  ram_col,
    output logic [6:0]  ram_wdata
);
    logic              word_vld, cs_rise, locked, sys_hold, erase_req;
    logic [WORD_W-1:0] word;
    logic [CODE_W-1:0] cur_cmd;
    axis_cfg_t         vcfg, hcfg;
    logic              ser_we, er_we;
    logic [ROW_W-1:0]  ser_row, er_row;
    logic [COL_W-1:0]  ser_col, er_col;
    logic [CHAR_W-1:0] ser_wdata, er_data;

    osd_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_csn(ser_csn), .word_vld(word_vld), .word(word), .cs_rise(cs_rise)
    );

    osd_cmd_fsm #(.ROWS(ROWS), .COLS(COLS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
        .cs_rise(cs_rise), .cur_cmd(cur_cmd), .locked(locked),
        .sys_hold(sys_hold), .vcfg(vcfg), .hcfg(hcfg),
        .disp_ctrl(disp_ctrl), .sync_ctrl(sync_ctrl), .erase_req(erase_req),
        .ser_we(ser_we), .ser_row(ser_row), .ser_col(ser_col),
        .ser_wdata(ser_wdata)
    );

    osd_erase_seq #(.ROWS(ROWS), .COLS(COLS)) u_erase (
        .clk(clk), .rst_n(rst_n), .clr(sys_hold), .erase_req(erase_req),
        .disp_on(disp_ctrl[0]), .stall(ser_we), .er_we(er_we),
        .er_row(er_row), .er_col(er_col), .er_data(er_data)
    );

    // Field outputs and shared write port
    always_comb begin
        vpos      = vcfg.pos;
        vsize     = vcfg.size;
        hpos      = hcfg.pos;
        hsize     = hcfg.size;
        ram_we    = ser_we | er_we;
        ram_row   = ser_we ? ser_row   : er_row;
        ram_col   = ser_we ? ser_col   : er_col;
        ram_wdata = ser_we ? ser_wdata : er_data;
    end
endmodule

// File: rtl/osd_cmd_chk.sv
// Checker: temporal properties of the decoder, bound into the top module.
module osd_cmd_chk
    import osd_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ram_we,
    input logic [3:0]        ram_row,
    input logic [4:0]        ram_col,
    input logic              ser_we,
    input logic              er_we,
    input logic              cs_rise,
    input logic [CODE_W-1:0] cur_cmd,
    input logic              locked,
    input logic              sys_hold,
    input logic [6:0]        disp_ctrl,
    input logic [5:0]        vpos,
    input logic [5:0]        hpos
);
    localparam logic [3:0] LAST_ROW = 4'(ROWS - 1);
    localparam logic [4:0] LAST_COL = 5'(COLS - 1);

    // R8
    ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_row <= LAST_ROW && ram_col <= LAST_COL));

    // R12
    erase_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        er_we |-> !disp_ctrl[0]);

    // R12
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_we && er_we));

    // R9
    cs_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (cur_cmd == CMD_ADDR && !locked));

    // R5
    lock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (cur_cmd == CMD_CHAR));

    // R13
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hold |=> (disp_ctrl == '0 && vpos == '0 && hpos == '0));
endmodule

bind osd_cmd_decoder osd_cmd_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_row(ram_row),
    .ram_col(ram_col), .ser_we(ser_we), .er_we(er_we), .cs_rise(cs_rise),
    .cur_cmd(cur_cmd), .locked(locked), .sys_hold(sys_hold),
    .disp_ctrl(disp_ctrl), .vpos(vpos), .hpos(hpos)
);

// File: tb/osd_cmd_decoder_test.sv
module osd_cmd_decoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic csn = 1'b1;
    logic [5:0] vpos, hpos;
    logic [1:0] vsize, hsize;
    logic [6:0] disp_ctrl;
    logic [2:0] sync_ctrl;
    logic       ram_we;
    logic [3:0] ram_row;
    logic [4:0] ram_col;
    logic [6:0] ram_wdata;

    int checks = 0;
    int errors = 0;
    int log_n = 0;
    int log_row [1024];
    int log_col [1024];
    int log_dat [1024];

    always #2.5 clk = ~clk;

    osd_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_dat(sdat), .ser_csn(csn),
        .vpos(vpos), .vsize(vsize), .hpos(hpos), .hsize(hsize),
        .disp_ctrl(disp_ctrl), .sync_ctrl(sync_ctrl), .ram_we(ram_we),
        .ram_row(ram_row), .ram_col(ram_col), .ram_wdata(ram_wdata)
    );

    // Capture every memory write strobe
    always @(negedge clk) begin
        if (rst_n && ram_we && log_n < 1024) begin
            log_row[log_n] = int'(ram_row);
            log_col[log_n] = int'(ram_col);
            log_dat[log_n] = int'(ram_wdata);
            log_n = log_n + 1;
        end
    end

    task automatic check_eq(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        wait_clk(2); csn = 1'b0; wait_clk(10);
    endtask

    task automatic cs_high();
        wait_clk(10); csn = 1'b1; wait_clk(20);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sdat = b[i];
            wait_clk(10); sclk = 1'b1;
            wait_clk(10); sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic check_wr(input string tag, input int idx, input int r, input int c, input int d);
        check_eq({tag, " row"}, log_row[idx], r);
        check_eq({tag, " col"}, log_col[idx], c);
        check_eq({tag, " data"}, log_dat[idx], d);
    endtask

    task automatic t_reset();
        // R14: all fields zero, no strobe
        check_eq("R14 vpos", int'(vpos), 0);
        check_eq("R14 hpos", int'(hpos), 0);
        check_eq("R14 sizes", int'({vsize, hsize}), 0);
        check_eq("R14 disp_ctrl", int'(disp_ctrl), 0);
        check_eq("R14 sync_ctrl", int'(sync_ctrl), 0);
        check_eq("R14 ram_we", int'(ram_we), 0);
    endtask

    task automatic t_position();
        cs_low();
        send(8'hA5); send(8'h15);
        wait_clk(10);
        check_eq("R10 vsize", int'(vsize), 3);
        check_eq("R1 R10 vpos msb first", int'(vpos), 8'h15);
        send(8'h2A);
        wait_clk(10);
        check_eq("R3 sticky vpos", int'(vpos), 8'h2A);
        send(8'hB1); send(8'h3F);
        cs_high();
        check_eq("R10 hsize", int'(hsize), 1);
        check_eq("R10 hpos", int'(hpos), 63);
    endtask

    task automatic t_framing();
        cs_low();
        send_bits(8'hFF, 4);
        cs_high();
        send_bits(8'hFF, 3);
        cs_low();
        send(8'hA0); send(8'h09);
        cs_high();
        check_eq("R1 partial word dropped", int'(vpos), 9);
        check_eq("R1 vsize from new command", int'(vsize), 0);
    endtask

    task automatic t_disp_sync();
        cs_low();
        send(8'hC0); send(8'h55); send(8'hD5);
        cs_high();
        check_eq("R11 disp_ctrl", int'(disp_ctrl), 8'h55);
        check_eq("R11 sync_ctrl", int'(sync_ctrl), 5);
    endtask

    task automatic t_bad_code();
        int mark = log_n;
        cs_low();
        send(8'hE0); send(8'h03);
        send(8'hF0); send(8'h11);
        cs_high();
        check_eq("R2 disp_ctrl kept", int'(disp_ctrl), 8'h55);
        check_eq("R2 vpos kept", int'(vpos), 9);
        check_eq("R2 no writes", log_n - mark, 0);
    endtask

    task automatic t_char();
        int mark = log_n;
        cs_low();
        send(8'h83); send(8'h05); send(8'h90);
        send(8'h41); send(8'hA5);
        cs_high();
        check_eq("R5 R6 write count", log_n - mark, 2);
        check_wr("R4 R6 first", mark, 3, 5, 8'h01);
        check_wr("R5 R6 top bit as data", mark + 1, 3, 6, 8'h65);
        check_eq("R5 vsize untouched", int'(vsize), 0);
        mark = log_n;
        cs_low();
        send(8'h07); send(8'h90); send(8'h3F);
        cs_high();
        check_eq("R9 write count", log_n - mark, 1);
        check_wr("R9 column after cs", mark, 3, 7, 8'h3F);
    endtask

    task automatic t_wrap();
        int mark = log_n;
        cs_low();
        send(8'h85); send(8'h16); send(8'h90);
        send(8'h01); send(8'h02); send(8'h03);
        cs_high();
        cs_low();
        send(8'h89); send(8'h17); send(8'h90);
        send(8'h04); send(8'h05);
        cs_high();
        check_eq("R7 write count", log_n - mark, 5);
        check_wr("R7 col22", mark, 5, 22, 1);
        check_wr("R7 col23", mark + 1, 5, 23, 2);
        check_wr("R7 next row", mark + 2, 6, 0, 3);
        check_wr("R7 last cell", mark + 3, 9, 23, 4);
        check_wr("R7 wrap to top", mark + 4, 0, 0, 5);
    endtask

    task automatic t_range();
        int mark = log_n;
        cs_low();
        send(8'h8C); send(8'h02); send(8'h90); send(8'h11);
        cs_high();
        cs_low();
        send(8'h83); send(8'h1E); send(8'h90); send(8'h11); send(8'h12);
        cs_high();
        check_eq("R8 no out-of-range writes", log_n - mark, 0);
        cs_low();
        send(8'h02); send(8'h90); send(8'h13);
        cs_high();
        check_eq("R8 write count after fix", log_n - mark, 1);
        check_wr("R8 row unchanged", mark, 3, 2, 8'h13);
    endtask

    task automatic t_erase();
        int mark = log_n;
        int bad = 0;
        int distinct = 0;
        logic [239:0] seen = '0;
        cs_low();
        send(8'hC4);
        wait_clk(400);
        check_eq("R12 waits while display on", log_n - mark, 0);
        send(8'h00);
        cs_high();
        wait_clk(400);
        check_eq("R12 display off", int'(disp_ctrl), 0);
        check_eq("R12 erase count", log_n - mark, 240);
        for (int i = mark; i < log_n; i++) begin
            if (log_dat[i] != 8'h3F) bad++;
            if (log_row[i] < 10 && log_col[i] < 24) seen[log_row[i] * 24 + log_col[i]] = 1'b1;
        end
        for (int k = 0; k < 240; k++) if (seen[k]) distinct++;
        check_eq("R12 non-blank data", bad, 0);
        check_eq("R12 cells covered", distinct, 240);
    endtask

    task automatic t_sysrst();
        cs_low();
        send(8'hA0); send(8'h12); send(8'hC0); send(8'h01);
        cs_high();
        check_eq("R13 setup disp", int'(disp_ctrl), 1);
        cs_low();
        send(8'hC1); send(8'h01); send(8'h85);
        wait_clk(10);
        check_eq("R13 disp cleared and held", int'(disp_ctrl), 0);
        check_eq("R13 vpos cleared", int'(vpos), 0);
        cs_high();
        cs_low();
        send(8'hC0); send(8'h01);
        cs_high();
        check_eq("R13 released after cs", int'(disp_ctrl), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all R actual=timeout expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(8);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        check_eq("R14 no writes", log_n, 0);
        t_position();
        t_framing();
        t_disp_sync();
        t_bad_code();
        t_char();
        t_wrap();
        t_range();
        t_erase();
        t_sysrst();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule